// File: doc/BRIEF.md
# Converter Enable Sequencer with Latched Fault Safe State

This block is the digital supervisor of an isolated power converter. It watches an enable request, a vector of fault flags and the digitized output voltages with their regulation setpoints. From these it drives three outputs: a switching-enable line, a soft-start request for an external ramp generator, and an active-low power-good flag.

A normal power-up runs from off, through soft start, to run. Dropping the enable returns the block to off. Any fault flag forces a latched safe state with switching stopped. The block stays in that state after the fault goes away. To leave it, every fault must be clear and the enable must stay low for a qualified interval of about 150 µs, counted in clock cycles. Raising the enable after that interval starts a fresh soft start.

Power-good is asserted only while running fault-free with every output inside a ±10% band around its setpoint.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: While rst_n is low and after its release, the block is in OFF with sw_en=0, ss_req=0 and pg_n=1.
- R2: en_in and every fault_in bit pass through a two-flop synchronizer. A change on these inputs first affects the state, and so sw_en, ss_req and pg_n, after the third rising clock edge that follows it.
- R3: In OFF, with the synchronized enable high and no synchronized fault, the block enters SOFT_START. SOFT_START drives sw_en=1 and ss_req=1.
- R4: In SOFT_START, with ss_done=1, enable high and no fault, the block enters RUN. RUN drives sw_en=1 and ss_req=0.
- R5: In SOFT_START or RUN, with the synchronized enable low and no fault, the block returns to OFF, where sw_en=0 and ss_req=0.
- R6: In any state other than LATCHED, a synchronized fault (any bit of fault_in set) moves the block to LATCHED on the next edge. LATCHED drives sw_en=0 and ss_req=0, and the block stays there after the fault clears.
- R7: A low counter advances on each cycle in which the synchronized enable is low and no fault is present. It restarts at zero on any cycle with the enable high or a fault present, and it saturates at QUAL_CYC = CLK_HZ·150/10^6 cycles. While the block is LATCHED, a cycle that finds the counter at QUAL_CYC arms the release, and a fault disarms it. An armed block seeing the enable high with no fault enters SOFT_START.
- R8: pg_n is low only in RUN, with no synchronized fault, and with every channel satisfying 10·|v−set| ≤ set. Channel i of v_meas and v_set occupies bits [i·W +: W] as unsigned values. In all other cycles pg_n is high.
- R9: pg_n is high in OFF, SOFT_START and LATCHED whatever the voltages are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Enable request, active high, asynchronous |
| fault_in | input | NF | Fault flags, any bit set is a fault, asynchronous |
| ss_done | input | 1 | Soft-start ramp finished, synchronous |
| v_meas | input | NCH*W | Measured output voltages, unsigned per channel |
| v_set | input | NCH*W | Regulation setpoints, unsigned per channel |
| sw_en | output | 1 | Converter switching enable |
| ss_req | output | 1 | Soft-start request |
| pg_n | output | 1 | Power-good, active low |

## Verification
Two events can meet in one cycle. A fault can arrive in the same cycle as a soft-start completion or an enable drop, and the fault must win. An enable rise can also meet a fault or the end of the low-time count while the block is latched. Random stimulus toggles the enable, the faults and ss_done at independent rates so that these coincidences occur, and directed sequences place a fault or an enable blip inside the qualifying low interval. Every cycle is judged against a bench model built from the requirements, which predicts the three outputs and evaluates the voltage window with a 9/10–11/10 bound instead of an absolute difference.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_SOFT    = 2'd1,
    ST_RUN     = 2'd2,
    ST_LATCHED = 2'd3
  } sup_state_t;
endpackage

// File: rtl/sync2_stage.sv
module sync2_stage #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_out  <= '0;
    end else begin
      meta_q <= d_in;
      q_out  <= meta_q;
    end
  end
endmodule

// File: rtl/volt_window.sv
module volt_window #(
  parameter int NCH = 2,
  parameter int W   = 12
) (
  input  logic [NCH*W-1:0] v_meas,
  input  logic [NCH*W-1:0] v_set,
  output logic             all_ok
);
  localparam int XW = W + 4;

  function automatic logic within_tenth(input logic [W-1:0] v, input logic [W-1:0] s);
    logic [XW-1:0] diff;
    logic [XW-1:0] lim;
    diff = (v > s) ? XW'(v - s) : XW'(s - v);
    lim  = XW'(s);
    return (diff * XW'(10)) <= lim;
  endfunction

  logic [NCH-1:0] ch_ok;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_ok[i] = within_tenth(v_meas[i*W +: W], v_set[i*W +: W]);
  end

  assign all_ok = &ch_ok;
endmodule

// File: rtl/low_timer.sv
module low_timer #(
  parameter int QUAL_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic flt_s,
  output logic qual
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (en_s || flt_s)     cnt_q <= '0;
    else if (cnt_q != CW'(QUAL_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual = (cnt_q == CW'(QUAL_CYC));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(QUAL_CYC)); // R7
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s || flt_s) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
  import pwr_seq_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int NF     = 4,
  parameter int NCH    = 2,
  parameter int W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic [NF-1:0]    fault_in,
  input  logic             ss_done,
  input  logic [NCH*W-1:0] v_meas,
  input  logic [NCH*W-1:0] v_set,
  output logic             sw_en,
  output logic             ss_req,
  output logic             pg_n
);
  localparam int QUAL_CYC = (CLK_HZ / 1000) * 150 / 1000;

  logic          en_s;
  logic [NF-1:0] flt_vec_s;
  logic          flt_s;
  logic          qual;
  logic          win_ok;
  logic          armed_q;
  logic          release_ev;
  sup_state_t    st_q, st_d;

  sync2_stage #(.WIDTH(NF + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({en_in, fault_in}),
    .q_out ({en_s, flt_vec_s})
  );

  assign flt_s = |flt_vec_s;

  low_timer #(.QUAL_CYC(QUAL_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en_s  (en_s),
    .flt_s (flt_s),
    .qual  (qual)
  );

  volt_window #(.NCH(NCH), .W(W)) u_win (
    .v_meas (v_meas),
    .v_set  (v_set),
    .all_ok (win_ok)
  );

  assign release_ev = (st_q == ST_LATCHED) && armed_q && en_s && !flt_s;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:     if (flt_s) st_d = ST_LATCHED;
                  else if (en_s) st_d = ST_SOFT;
      ST_SOFT:    if (flt_s) st_d = ST_LATCHED;
                  else if (!en_s) st_d = ST_OFF;
                  else if (ss_done) st_d = ST_RUN;
      ST_RUN:     if (flt_s) st_d = ST_LATCHED;
                  else if (!en_s) st_d = ST_OFF;
      ST_LATCHED: if (release_ev) st_d = ST_SOFT;
      default:    st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      armed_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q != ST_LATCHED || flt_s) armed_q <= 1'b0;
      else if (qual)                    armed_q <= 1'b1;
    end
  end

  assign sw_en  = (st_q == ST_SOFT) || (st_q == ST_RUN);
  assign ss_req = (st_q == ST_SOFT);
  assign pg_n   = !((st_q == ST_RUN) && !flt_s && win_ok);

  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_s && st_q != ST_LATCHED) |=> (st_q == ST_LATCHED)); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCHED && !armed_q) |=> (st_q == ST_LATCHED)); // R7
  AST_ARM_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(qual)); // R7
  AST_SS_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOFT && ss_done && en_s && !flt_s) |=> (st_q == ST_RUN)); // R4
  AST_EN_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !flt_s && sw_en) |=> (st_q == ST_OFF)); // R5
  AST_PG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n |-> win_ok); // R8
  AST_PG_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n |-> (sw_en && !ss_req)); // R9
endmodule

// File: tb/sim_pwr_seq_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_seq_supervisor;
  localparam int CLK_HZ = 200_000;
  localparam int NF     = 4;
  localparam int NCH    = 2;
  localparam int W      = 12;
  localparam int QUAL   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_in = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic ss_done = 1'b0;
  logic [NCH*W-1:0] v_meas = '0;
  logic [NCH*W-1:0] v_set = '0;
  logic sw_en, ss_req, pg_n;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_seq_supervisor #(.CLK_HZ(CLK_HZ), .NF(NF), .NCH(NCH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .fault_in(fault_in),
    .ss_done(ss_done), .v_meas(v_meas), .v_set(v_set),
    .sw_en(sw_en), .ss_req(ss_req), .pg_n(pg_n)
  );

  // bench model: 0=OFF 1=SOFT 2=RUN 3=LATCHED
  logic e1, e2, f1, f2;
  int   mst, mcnt;
  logic marm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1 <= 0; e2 <= 0; f1 <= 0; f2 <= 0;
      mst <= 0; mcnt <= 0; marm <= 0;
    end else begin
      e1 <= en_in; e2 <= e1;
      f1 <= (fault_in != 0); f2 <= f1;
      mcnt <= (e2 || f2) ? 0 : ((mcnt < QUAL) ? mcnt + 1 : mcnt);
      marm <= (mst != 3 || f2) ? 1'b0 : (marm || mcnt == QUAL);
      case (mst)
        0: mst <= f2 ? 3 : (e2 ? 1 : 0);
        1: mst <= f2 ? 3 : (!e2 ? 0 : (ss_done ? 2 : 1));
        2: mst <= f2 ? 3 : (!e2 ? 0 : 2);
        default: mst <= (marm && e2 && !f2) ? 1 : 3;
      endcase
    end
  end

  function automatic bit band_ok(input logic [NCH*W-1:0] vm, input logic [NCH*W-1:0] vs);
    bit ok = 1;
    for (int i = 0; i < NCH; i++) begin
      int unsigned v = vm[i*W +: W];
      int unsigned s = vs[i*W +: W];
      if (v * 10 < s * 9 || v * 10 > s * 11) ok = 0;
    end
    return ok;
  endfunction

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int esw, ess, epg;
    esw = (mst == 1 || mst == 2);
    ess = (mst == 1);
    epg = !(mst == 2 && !f2 && band_ok(v_meas, v_set));
    chk(sw_en == esw, (mst == 3) ? "R6 sw_en" : "R3/R5 sw_en", sw_en, esw);
    chk(ss_req == ess, (mst == 1) ? "R3 ss_req" : "R4 ss_req", ss_req, ess);
    chk(pg_n == epg, (mst == 2) ? "R8 pg_n" : "R9 pg_n", pg_n, epg);
  endtask

  task automatic set_volts(input int pct_spread);
    for (int i = 0; i < NCH; i++) begin
      int s = 1000 + $urandom_range(0, 2000);
      int off = $urandom_range(0, 2 * pct_spread) - pct_spread;
      v_set[i*W +: W] = W'(s);
      v_meas[i*W +: W] = W'(s + (s * off) / 100);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    set_volts(5);
    repeat (3) @(negedge clk);
    chk(sw_en == 0 && ss_req == 0 && pg_n == 1, "R1 in reset", {sw_en, ss_req, pg_n}, 1);
    rst_n = 1'b1;
    step(2);
    chk(sw_en == 0 && pg_n == 1, "R1 after reset", {sw_en, pg_n}, 1);

    // R2/R3: enable latency of three edges
    en_in = 1'b1;
    @(negedge clk); chk(sw_en == 0, "R2 edge1", sw_en, 0);
    @(negedge clk); chk(sw_en == 0, "R2 edge2", sw_en, 0);
    @(negedge clk); chk(sw_en == 1 && ss_req == 1, "R2 R3 edge3", {sw_en, ss_req}, 3);
    step(3);
    chk(pg_n == 1, "R9 soft start", pg_n, 1);
    ss_done = 1'b1; step(1); ss_done = 1'b0; step(2);
    chk(sw_en == 1 && ss_req == 0, "R4 run", {sw_en, ss_req}, 2);
    chk(pg_n == 0, "R8 in band", pg_n, 0);
    v_meas[W-1:0] = W'((int'(v_set[W-1:0]) * 12) / 10);
    step(1);
    chk(pg_n == 1, "R8 out of band", pg_n, 1);
    set_volts(5); step(2);

    // R6: fault together with enable drop, fault wins
    fault_in = 4'b0100; en_in = 1'b0;
    step(1); fault_in = '0; step(4);
    chk(sw_en == 0 && ss_req == 0, "R6 latched", {sw_en, ss_req}, 0);

    // R7: enable blip during low count, then fault during low count
    step(QUAL / 2); en_in = 1'b1; step(1); en_in = 1'b0; step(QUAL / 2 + 4);
    fault_in = 4'b0001; step(1); fault_in = '0; step(QUAL / 2);
    en_in = 1'b1; step(6);
    chk(sw_en == 0, "R7 early release refused", sw_en, 0);
    en_in = 1'b0; step(QUAL + 6);
    en_in = 1'b1; step(4);
    chk(sw_en == 1 && ss_req == 1, "R7 release to soft start", {sw_en, ss_req}, 3);

    // random phase
    for (int n = 0; n < 40000; n++) begin
      @(negedge clk);
      check_all();
      if ($urandom_range(0, 59) == 0) en_in = ~en_in;
      fault_in = ($urandom_range(0, 299) == 0) ? NF'($urandom_range(1, 15)) : '0;
      ss_done = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 49) == 0) set_volts(14);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule